// File: doc/BRIEF.md
# Banked Interrupt Enable Bank

This block keeps the enable state of every interrupt line in a small multi-processor interrupt distributor, which by default has 64 lines and two processors. Low-numbered private lines, below 32 by default, keep a separate enable bit for each processor. All higher, shared lines keep one enable bit that every processor sees. The block exports the full per-processor enable view as a flat vector for the arbiter to read.

Software reaches the state through two byte-wide windows, one for setting and one for clearing. Each access carries the number of the processor that makes it and a byte offset. Offset k covers interrupt IDs 8k to 8k+7. A write changes only the bits written as 1. A read of either window returns the enables that the accessing processor sees.

When software enables a level-triggered line whose input is high, the block emits a one-cycle pending request. For a private line the request goes to the writing processor. For a shared line it goes to that line's target processors. The arbiter and the pending store sit outside this block.

Top module: `enb_bank_top`

## Requirements
- R1: After reset, IDs below 16 are enabled for every processor, all other IDs are disabled, and `pend_set` is all zero.
- R2: A write to the set window (`acc_write`=1, `acc_clear`=0) sets the enable of every ID in the addressed byte whose data bit is 1. Bits written as 0 leave their enable unchanged.
- R3: A write to the clear window (`acc_write`=1, `acc_clear`=1) clears the enable of every ID in the addressed byte whose data bit is 1. Bits written as 0 leave their enable unchanged.
- R4: For IDs below 32, a write changes only the enable bit of the processor named in `acc_cpu`. The bits of the other processors keep their values.
- R5: For IDs 32 and above, a write by any processor changes the single shared enable, and every processor sees the same value.
- R6: A read (`acc_valid`=1, `acc_write`=0) returns on `acc_rdata`, in the same cycle, the eight enables of the addressed byte as the accessing processor sees them. The value is the same for either window, and a read changes no state.
- R7: Byte offset k covers IDs 8k to 8k+7, with data bit b standing for ID 8k+b. In `en_vec`, bit c*64+i is the enable of ID i for processor c.
- R8: Offsets at or above 8 (64/8) read as zero, and writes to them change no enable.
- R9: A set-window write with bit 1 for a private ID that is level-triggered, and whose `priv_level` bit for the writing processor is 1, raises `pend_set[cpu*64+id]` in the cycle after the write, and only for that processor.
- R10: The same for a shared level-triggered ID whose `shr_level` is 1 raises `pend_set[c*64+id]` for each processor c whose bit `shr_target[(id-32)*2+c]` is 1.
- R11: No pending request is made for an ID whose input level is 0, for an ID with `trig_edge` set to 1, or for IDs below 16, which are always edge-triggered.
- R12: A pending request lasts exactly one cycle unless a further enabling write repeats it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Window access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_clear | input | 1 | Window select: 0 = set window, 1 = clear window |
| acc_cpu | input | 1 | Number of the processor making the access |
| acc_offset | input | 4 | Byte offset within the window |
| acc_wdata | input | 8 | Write data, one bit per ID |
| acc_rdata | output | 8 | Read data, valid in the access cycle |
| priv_level | input | 64 | Input level of private IDs, bit c*32+i |
| shr_level | input | 32 | Input level of shared IDs, bit id-32 |
| trig_edge | input | 64 | Trigger mode per ID, 1 = edge |
| shr_target | input | 64 | Target processors per shared ID, bit (id-32)*2+c |
| en_vec | output | 128 | Enable seen by each processor, bit c*64+i |
| pend_set | output | 128 | One-cycle pending request, bit c*64+i |

## Verification
A corrupted enable bit shows on `en_vec` on the clock edge after the write that caused it. It shows on `acc_rdata` as soon as that byte is read by the affected processor. A write that lands in the wrong processor's bank or in the wrong byte leaves a difference against a per-bit model of both banks, and a full-vector comparison after every write exposes it at once. A wrong pending decision shows on `pend_set` in the single cycle after the enabling write. It is checked in that cycle and again in the cycle that follows, for targets, trigger mode and level.

// File: rtl/enb_pkg.sv
package enb_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE = 2'd0,
        ACC_READ = 2'd1,
        ACC_SET  = 2'd2,
        ACC_CLR  = 2'd3
    } acc_kind_e;

endpackage

// File: rtl/enb_win_decode.sv
module enb_win_decode
    import enb_pkg::*;
#(
    parameter int NUM_IRQ = 64,
    parameter int OFF_W   = 4
) (
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic               acc_clear,
    input  logic [OFF_W-1:0]   acc_offset,
    input  logic [7:0]         acc_wdata,
    output acc_kind_e          kind,
    output logic [NUM_IRQ/8-1:0] lane_hit,
    output logic               in_range,
    output logic [NUM_IRQ-1:0] set_mask,
    output logic [NUM_IRQ-1:0] clr_mask
);
    localparam int NUM_BYTES = NUM_IRQ / 8;

    always_comb begin
        if (!acc_valid)     kind = ACC_IDLE;
        else if (!acc_write) kind = ACC_READ;
        else if (acc_clear) kind = ACC_CLR;
        else                kind = ACC_SET;
        in_range = acc_offset < OFF_W'(NUM_BYTES);
    end

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_lane
        always_comb begin
            lane_hit[k]         = acc_valid && (acc_offset == OFF_W'(k));
            set_mask[k*8 +: 8]  = (lane_hit[k] && kind == ACC_SET) ? acc_wdata : 8'h00;
            clr_mask[k*8 +: 8]  = (lane_hit[k] && kind == ACC_CLR) ? acc_wdata : 8'h00;
        end
    end
endmodule

// File: rtl/enb_priv_bank.sv
module enb_priv_bank #(
    parameter int NUM_CPU     = 2,
    parameter int PRIV_IRQ    = 32,
    parameter int ALWAYS_EDGE = 16,
    parameter int CPU_W       = 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [CPU_W-1:0]             acc_cpu,
    input  logic [PRIV_IRQ-1:0]          set_mask,
    input  logic [PRIV_IRQ-1:0]          clr_mask,
    input  logic [NUM_CPU*PRIV_IRQ-1:0]  level,
    input  logic [PRIV_IRQ-1:0]          edge_cfg,
    output logic [NUM_CPU*PRIV_IRQ-1:0]  en,
    output logic [NUM_CPU*PRIV_IRQ-1:0]  pend
);
    localparam int NB = NUM_CPU * PRIV_IRQ;

    typedef struct packed {
        logic [NB-1:0] en;
        logic [NB-1:0] pend;
    } st_t;

    function automatic logic [NB-1:0] en_reset();
        logic [NB-1:0] v;
        for (int c = 0; c < NUM_CPU; c++)
            for (int i = 0; i < PRIV_IRQ; i++)
                v[c*PRIV_IRQ+i] = (i < ALWAYS_EDGE);
        return v;
    endfunction

    localparam logic [NB-1:0] EN_RST = en_reset();

    st_t st_d, st_q;
    logic [PRIV_IRQ-1:0] edge_eff;

    for (genvar i = 0; i < PRIV_IRQ; i++) begin : g_edge
        if (i < ALWAYS_EDGE) begin : g_fixed
            assign edge_eff[i] = 1'b1;
        end else begin : g_cfg
            assign edge_eff[i] = edge_cfg[i];
        end
    end

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NUM_CPU; c++) begin
            for (int i = 0; i < PRIV_IRQ; i++) begin
                st_d.pend[c*PRIV_IRQ+i] = 1'b0;
                if (acc_cpu == CPU_W'(c)) begin
                    if (set_mask[i]) st_d.en[c*PRIV_IRQ+i] = 1'b1;
                    if (clr_mask[i]) st_d.en[c*PRIV_IRQ+i] = 1'b0;
                    st_d.pend[c*PRIV_IRQ+i] = set_mask[i] && level[c*PRIV_IRQ+i]
                                              && !edge_eff[i];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.en   <= EN_RST;
            st_q.pend <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en   = st_q.en;
    assign pend = st_q.pend;

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk_cpu
        for (genvar i = 0; i < PRIV_IRQ; i++) begin : g_chk_id
            p_set_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (set_mask[i] && acc_cpu == CPU_W'(c)) |=> en[c*PRIV_IRQ+i]);
            p_clear_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_mask[i] && acc_cpu == CPU_W'(c)) |=> !en[c*PRIV_IRQ+i]);
            p_other_bank_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (acc_cpu != CPU_W'(c)) |=> $stable(en[c*PRIV_IRQ+i]));
            p_pend_writer_r9: assert property (@(posedge clk) disable iff (!rst_n)
                pend[c*PRIV_IRQ+i] |-> $past(set_mask[i] && acc_cpu == CPU_W'(c)
                                             && level[c*PRIV_IRQ+i]));
            p_edge_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
                pend[c*PRIV_IRQ+i] |-> $past(!edge_eff[i]));
        end
    end
endmodule

// File: rtl/enb_shared_bank.sv
module enb_shared_bank #(
    parameter int NUM_CPU = 2,
    parameter int NUM_SH  = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SH-1:0]           set_mask,
    input  logic [NUM_SH-1:0]           clr_mask,
    input  logic [NUM_SH-1:0]           level,
    input  logic [NUM_SH-1:0]           edge_cfg,
    input  logic [NUM_SH*NUM_CPU-1:0]   target,
    output logic [NUM_SH-1:0]           en,
    output logic [NUM_CPU*NUM_SH-1:0]   pend
);
    typedef struct packed {
        logic [NUM_SH-1:0]         en;
        logic [NUM_CPU*NUM_SH-1:0] pend;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int j = 0; j < NUM_SH; j++) begin
            if (set_mask[j]) st_d.en[j] = 1'b1;
            if (clr_mask[j]) st_d.en[j] = 1'b0;
            for (int c = 0; c < NUM_CPU; c++)
                st_d.pend[c*NUM_SH+j] = set_mask[j] && level[j] && !edge_cfg[j]
                                        && target[j*NUM_CPU+c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign en   = st_q.en;
    assign pend = st_q.pend;

    for (genvar j = 0; j < NUM_SH; j++) begin : g_chk_id
        p_set_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
            set_mask[j] |=> en[j]);
        p_clear_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
            clr_mask[j] |=> !en[j]);
        p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !(set_mask[j] || clr_mask[j]) |=> $stable(en[j]));
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk_cpu
            p_pend_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
                pend[c*NUM_SH+j] |-> $past(target[j*NUM_CPU+c] && set_mask[j] && level[j]));
            p_edge_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
                pend[c*NUM_SH+j] |-> $past(!edge_cfg[j]));
        end
    end
endmodule

// File: rtl/enb_bank_top.sv
module enb_bank_top
    import enb_pkg::*;
#(
    parameter int NUM_IRQ     = 64,
    parameter int NUM_CPU     = 2,
    parameter int PRIV_IRQ    = 32,
    parameter int ALWAYS_EDGE = 16,
    parameter int OFF_W       = 4,
    localparam int CPU_W      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int NUM_SH     = NUM_IRQ - PRIV_IRQ,
    localparam int NUM_BYTES  = NUM_IRQ / 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          acc_valid,
    input  logic                          acc_write,
    input  logic                          acc_clear,
    input  logic [CPU_W-1:0]              acc_cpu,
    input  logic [OFF_W-1:0]              acc_offset,
    input  logic [7:0]                    acc_wdata,
    output logic [7:0]                    acc_rdata,
    input  logic [NUM_CPU*PRIV_IRQ-1:0]   priv_level,
    input  logic [NUM_SH-1:0]             shr_level,
    input  logic [NUM_IRQ-1:0]            trig_edge,
    input  logic [NUM_SH*NUM_CPU-1:0]     shr_target,
    output logic [NUM_CPU*NUM_IRQ-1:0]    en_vec,
    output logic [NUM_CPU*NUM_IRQ-1:0]    pend_set
);
    acc_kind_e                   kind;
    logic [NUM_BYTES-1:0]        lane_hit;
    logic                        in_range;
    logic [NUM_IRQ-1:0]          set_mask, clr_mask;
    logic [NUM_CPU*PRIV_IRQ-1:0] priv_en, priv_pend;
    logic [NUM_SH-1:0]           shr_en;
    logic [NUM_CPU*NUM_SH-1:0]   shr_pend;
    logic [NUM_IRQ-1:0]          view;

    enb_win_decode #(.NUM_IRQ(NUM_IRQ), .OFF_W(OFF_W)) u_dec (
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_clear  (acc_clear),
        .acc_offset (acc_offset),
        .acc_wdata  (acc_wdata),
        .kind       (kind),
        .lane_hit   (lane_hit),
        .in_range   (in_range),
        .set_mask   (set_mask),
        .clr_mask   (clr_mask)
    );

    enb_priv_bank #(
        .NUM_CPU(NUM_CPU), .PRIV_IRQ(PRIV_IRQ),
        .ALWAYS_EDGE(ALWAYS_EDGE), .CPU_W(CPU_W)
    ) u_priv (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc_cpu  (acc_cpu),
        .set_mask (set_mask[PRIV_IRQ-1:0]),
        .clr_mask (clr_mask[PRIV_IRQ-1:0]),
        .level    (priv_level),
        .edge_cfg (trig_edge[PRIV_IRQ-1:0]),
        .en       (priv_en),
        .pend     (priv_pend)
    );

    enb_shared_bank #(.NUM_CPU(NUM_CPU), .NUM_SH(NUM_SH)) u_shr (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_mask (set_mask[NUM_IRQ-1:PRIV_IRQ]),
        .clr_mask (clr_mask[NUM_IRQ-1:PRIV_IRQ]),
        .level    (shr_level),
        .edge_cfg (trig_edge[NUM_IRQ-1:PRIV_IRQ]),
        .target   (shr_target),
        .en       (shr_en),
        .pend     (shr_pend)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_view
        assign en_vec[c*NUM_IRQ +: PRIV_IRQ]            = priv_en[c*PRIV_IRQ +: PRIV_IRQ];
        assign en_vec[c*NUM_IRQ+PRIV_IRQ +: NUM_SH]     = shr_en;
        assign pend_set[c*NUM_IRQ +: PRIV_IRQ]          = priv_pend[c*PRIV_IRQ +: PRIV_IRQ];
        assign pend_set[c*NUM_IRQ+PRIV_IRQ +: NUM_SH]   = shr_pend[c*NUM_SH +: NUM_SH];
    end

    always_comb begin
        view = '0;
        for (int c = 0; c < NUM_CPU; c++)
            if (acc_cpu == CPU_W'(c)) view = en_vec[c*NUM_IRQ +: NUM_IRQ];
        acc_rdata = 8'h00;
        for (int k = 0; k < NUM_BYTES; k++)
            if (lane_hit[k] && kind == ACC_READ) acc_rdata = view[k*8 +: 8];
    end

    p_oor_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && !in_range) |=> $stable(en_vec));
    p_read_no_effect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == ACC_READ) |=> $stable(en_vec));
    p_oor_read_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !in_range) |-> acc_rdata == 8'h00);
endmodule

// File: tb/enb_bank_top_tb_top.sv
`timescale 1ns/1ps
module enb_bank_top_tb_top;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         acc_valid, acc_write, acc_clear;
    logic [0:0]   acc_cpu;
    logic [3:0]   acc_offset;
    logic [7:0]   acc_wdata, acc_rdata;
    logic [63:0]  priv_level;
    logic [31:0]  shr_level;
    logic [63:0]  trig_edge;
    logic [63:0]  shr_target;
    logic [127:0] en_vec, pend_set;

    int n_chk  = 0;
    int n_fail = 0;
    logic [127:0] m_en;

    always #2 clk = ~clk;

    enb_bank_top dut_i (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_clear(acc_clear), .acc_cpu(acc_cpu), .acc_offset(acc_offset),
        .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .priv_level(priv_level),
        .shr_level(shr_level), .trig_edge(trig_edge), .shr_target(shr_target),
        .en_vec(en_vec), .pend_set(pend_set)
    );

    typedef struct packed {
        logic       wr;
        logic       clr;
        logic       cpu;
        logic [3:0] off;
        logic [7:0] wd;
        logic       rcpu;
        logic [7:0] exp;
    } vec_t;

    localparam vec_t TBL [12] = '{
        '{1'b1, 1'b0, 1'b0, 4'd2, 8'h0F, 1'b0, 8'h0F},
        '{1'b1, 1'b0, 1'b0, 4'd2, 8'h00, 1'b1, 8'h00},
        '{1'b1, 1'b0, 1'b1, 4'd2, 8'hF0, 1'b1, 8'hF0},
        '{1'b1, 1'b1, 1'b0, 4'd2, 8'h03, 1'b0, 8'h0C},
        '{1'b1, 1'b0, 1'b1, 4'd5, 8'hA5, 1'b0, 8'hA5},
        '{1'b1, 1'b1, 1'b0, 4'd5, 8'h81, 1'b1, 8'h24},
        '{1'b1, 1'b1, 1'b1, 4'd0, 8'h00, 1'b1, 8'hFF},
        '{1'b1, 1'b1, 1'b1, 4'd0, 8'h10, 1'b1, 8'hEF},
        '{1'b0, 1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 8'hFF},
        '{1'b1, 1'b0, 1'b0, 4'd7, 8'h80, 1'b1, 8'h80},
        '{1'b1, 1'b0, 1'b0, 4'd9, 8'hFF, 1'b0, 8'h00},
        '{1'b1, 1'b0, 1'b0, 4'd4, 8'h01, 1'b1, 8'h01}
    };

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_en = '0;
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 16; i++) m_en[c*64+i] = 1'b1;
    endtask

    task automatic model_write(input bit clr, input int cpu, input int off,
                               input logic [7:0] wd);
        if (off >= 8) return;
        for (int b = 0; b < 8; b++) begin
            int id = off*8 + b;
            if (wd[b]) begin
                if (id < 32) m_en[cpu*64+id] = !clr;
                else for (int c = 0; c < 2; c++) m_en[c*64+id] = !clr;
            end
        end
    endtask

    task automatic do_write(input bit clr, input int cpu, input int off,
                            input logic [7:0] wd);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_clear = clr;
        acc_cpu = 1'(cpu); acc_offset = 4'(off); acc_wdata = wd;
        model_write(clr, cpu, off, wd);
        @(posedge clk);
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_clear = 1'b0;
    endtask

    task automatic do_read(input bit win, input int cpu, input int off,
                           output logic [7:0] rd);
        acc_valid = 1'b1; acc_write = 1'b0; acc_clear = win;
        acc_cpu = 1'(cpu); acc_offset = 4'(off);
        #1;
        rd = acc_rdata;
        acc_valid = 1'b0; acc_clear = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        logic [7:0]   rd;
        logic [127:0] exp_p;
        rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_clear = 1'b0;
        acc_cpu = '0; acc_offset = '0; acc_wdata = '0;
        priv_level = '0; shr_level = '0; trig_edge = '0; shr_target = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk(en_vec === m_en, "R1 reset enables", en_vec, m_en);
        chk(pend_set === '0, "R1 reset pending", pend_set, '0);
        do_read(1'b0, 1, 1, rd);
        chk(rd === 8'hFF, "R1 R7 byte1 read", {120'b0, rd}, 128'hFF);

        // Table walk: R2 R3 R4 R5 R7 R8 writes, then readback per R6
        for (int t = 0; t < 12; t++) begin
            if (TBL[t].wr) begin
                do_write(TBL[t].clr, int'(TBL[t].cpu), int'(TBL[t].off), TBL[t].wd);
                chk(en_vec === m_en, "R2 R3 R4 R5 R7 R8 table en_vec", en_vec, m_en);
                chk(pend_set === '0, "R11 low level no pend", pend_set, '0);
            end
            do_read(1'b0, int'(TBL[t].rcpu), int'(TBL[t].off), rd);
            chk(rd === TBL[t].exp, "R6 R7 table readback", {120'b0, rd}, {120'b0, TBL[t].exp});
        end

        // R4: banked private ID 20: cpu1 enabled, cpu0 not
        chk(en_vec[64+20] === 1'b1 && en_vec[20] === 1'b0, "R4 bank split",
            {126'b0, en_vec[64+20], en_vec[20]}, 128'b10);

        // R6: clear window read, then no side effect
        do_read(1'b1, 1, 2, rd);
        chk(rd === 8'hF0, "R6 clear window read", {120'b0, rd}, 128'hF0);
        @(negedge clk);
        chk(en_vec === m_en, "R6 read leaves state", en_vec, m_en);

        // R8: out-of-range clear write ignored, read zero
        do_write(1'b1, 0, 12, 8'hFF);
        chk(en_vec === m_en, "R8 oor write ignored", en_vec, m_en);
        do_read(1'b1, 0, 15, rd);
        chk(rd === 8'h00, "R8 oor read zero", {120'b0, rd}, 128'h0);

        // R9: private level-triggered ID 18, both levels high, cpu0 writes
        priv_level[18] = 1'b1; priv_level[32+18] = 1'b1;
        do_write(1'b0, 0, 2, 8'h04);
        exp_p = '0; exp_p[18] = 1'b1;
        chk(pend_set === exp_p, "R9 writer-only pend", pend_set, exp_p);
        chk(en_vec === m_en, "R9 enable set", en_vec, m_en);
        @(negedge clk);
        chk(pend_set === '0, "R12 pend one cycle", pend_set, '0);

        // R10: shared ID 40 targets cpu1 only
        shr_level[8] = 1'b1; shr_target[17:16] = 2'b10;
        do_write(1'b0, 0, 5, 8'h01);
        exp_p = '0; exp_p[64+40] = 1'b1;
        chk(pend_set === exp_p, "R10 shared target pend", pend_set, exp_p);
        @(negedge clk);
        chk(pend_set === '0, "R12 shared pend one cycle", pend_set, '0);

        // R10: both targets
        shr_target[17:16] = 2'b11;
        do_write(1'b0, 1, 5, 8'h01);
        exp_p = '0; exp_p[40] = 1'b1; exp_p[64+40] = 1'b1;
        chk(pend_set === exp_p, "R10 two targets", pend_set, exp_p);

        // R11: edge-configured shared ID, fixed-edge ID 3, low-level ID 41
        trig_edge[40] = 1'b1;
        do_write(1'b0, 0, 5, 8'h03);
        chk(pend_set === '0, "R11 edge cfg / low level", pend_set, '0);
        priv_level[3] = 1'b1;
        do_write(1'b0, 0, 0, 8'h08);
        chk(pend_set === '0, "R11 fixed edge ID3", pend_set, '0);

        // R12: back-to-back enabling writes repeat the request
        do_write(1'b0, 1, 2, 8'h04);
        exp_p = '0; exp_p[64+18] = 1'b1;
        chk(pend_set === exp_p, "R9 R12 repeat pend cpu1", pend_set, exp_p);

        // R1: reset again
        priv_level = '0; shr_level = '0; trig_edge = '0; shr_target = '0;
        do_reset();
        chk(en_vec === m_en, "R1 re-reset enables", en_vec, m_en);
        chk(pend_set === '0, "R1 re-reset pending", pend_set, '0);

        finish_run();
    end
endmodule